// File: doc/BRIEF.md
# Two-Dimensional Parity Correction Sequencer

This block repairs a small memory protected by two-dimensional parity. Each row of the memory is split into lanes of equal width, and each lane of each row carries one row check bit equal to the XOR of its data bits. A column check register, one bit per data column, holds the XOR of every row. When a read somewhere in the system finds a row check mismatch, it pulses the trigger with the index of the faulty row. The sequencer then takes over the memory's maintenance port and the column check register until the repair is complete.

The repair has two passes. In the first pass the sequencer saves the stored column check bits, reuses the column check register as an accumulator while it reads every row, and compares the rebuilt column parity with the saved copy to form a syndrome. A 1 in the syndrome marks a faulty data column. In the second pass it visits every row in turn. In each lane whose row parity is wrong, it flips the syndrome bits of that lane. It then writes the row back with freshly computed row check bits. At the end it rewrites the column check register with the parity of the repaired array. It also pulses done, together with a corrected flag and an uncorrectable flag for each lane.

The maintenance read is combinational: read data and row check bits for the driven address are valid in the same cycle. Writes to the memory and to the column check register take effect at the next clock edge.

Top module: `tdp_scrub_seq`

## Requirements
- R1: While reset is low and after it is released with no trigger, busy_o, done_o, mnt_we_o, cc_we_o, lane_fixed_o and lane_bad_o are all 0.
- R2: A trigger seen while idle raises busy_o from the next cycle. busy_o stays high for exactly 2*ROWS+2 cycles, and done_o is high only in the last of these cycles, as a one-cycle pulse.
- R3: The syndrome pass lasts ROWS+1 cycles and writes nothing to the memory. In its first ROWS cycles cc_we_o is 1 and mnt_addr_o steps through the rows in the order trig_row+1, trig_row+2, ..., wrapping from ROWS-1 to 0 and ending on trig_row. After these ROWS cycles the column check register holds the XOR of all data rows.
- R4: The scrub pass lasts ROWS cycles. It writes rows 0 to ROWS-1 in ascending order, one per cycle, with cc_we_o low. In each lane L (data bits L*LANE_W to L*LANE_W+LANE_W-1, row check bit L) whose stored row check bit differs from the XOR of its data bits, the lane's data is XORed with the syndrome bits of lane L. All other lanes are written back unchanged.
- R5: Each row check bit that is written equals the XOR of the data bits of its lane as written. This also repairs a flipped row check bit.
- R6: In the done cycle cc_we_o is 1, and the column check register is written with the XOR of all rows as they stand after the scrub.
- R7: In the done cycle a lane is flagged uncorrectable (lane_bad_o) if more than one row mismatched in that lane or its syndrome has more than one bit set. Otherwise it is flagged corrected (lane_fixed_o) if exactly one row mismatched or exactly one syndrome bit is set. The two flags are never both 1, and both are 0 outside the done cycle.
- R8: Two flipped bits in the same row and lane leave that row's parity intact, yet the lane is reported uncorrectable because the syndrome shows two bits.
- R9: A trigger that arrives while busy_o is high is ignored. The sequence continues with its original timing, addresses and results.
- R10: A single flipped row check bit or a single flipped column check bit is reported as corrected. The data is left unchanged, and the check bits are restored to match the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Row check mismatch report, starts a repair when idle |
| trig_row_i | input | AW | Index of the row that mismatched |
| busy_o | output | 1 | Repair in progress |
| done_o | output | 1 | One-cycle pulse on the last repair cycle |
| mnt_addr_o | output | AW | Maintenance port row address |
| mnt_rdata_i | input | DW | Data of the addressed row, same cycle |
| mnt_rchk_i | input | LANES | Row check bits of the addressed row, same cycle |
| mnt_we_o | output | 1 | Maintenance write enable |
| mnt_wdata_o | output | DW | Data written to the addressed row |
| mnt_wchk_o | output | LANES | Row check bits written to the addressed row |
| cc_q_i | input | DW | Current column check register contents |
| cc_we_o | output | 1 | Column check register write enable |
| cc_d_o | output | DW | Column check register write value |
| lane_fixed_o | output | LANES | Per-lane corrected flag, valid with done_o |
| lane_bad_o | output | LANES | Per-lane uncorrectable flag, valid with done_o |

## Verification
The assertions assume that the memory returns the addressed row in the same cycle, that the column check register shows a written value from the next cycle on, and that trig_row_i is below ROWS. They also assume that nothing else writes the memory or the column check register while busy_o is high. The bench meets these assumptions with a behavioural memory and register that respond only to the block's own ports. Faults are injected only while the sequencer is idle, and triggers use rows inside the array. The one exception is a deliberate retrigger during a repair, used to show that such a trigger is ignored.

// File: rtl/tdp_pkg.sv
// Shared types for the two-dimensional parity correction sequencer.
// Assumes nothing beyond the enum encoding being private to this block.
package tdp_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SAVE  = 3'd1,
        ST_ACCUM = 3'd2,
        ST_SYND  = 3'd3,
        ST_SCRUB = 3'd4,
        ST_FIN   = 3'd5
    } seq_st_t;

endpackage

// File: rtl/tdp_lane_fix.sv
// One lane of the scrub datapath. It checks the lane's row parity against the
// stored row check bit, applies the lane's syndrome bits on a mismatch, and
// produces the repaired data with a fresh row check bit.
// Assumes row check bit = XOR of the lane's data bits (even parity).
module tdp_lane_fix #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] rd_bits,
    input  logic              rd_chk,
    input  logic [LANE_W-1:0] syn_bits,
    output logic              mismatch,
    output logic [LANE_W-1:0] flip_bits,
    output logic [LANE_W-1:0] wr_bits,
    output logic              wr_chk
);

    // Compare recomputed row parity with stored check bit, then repair.
    always_comb begin
        mismatch  = (^rd_bits) ^ rd_chk;
        flip_bits = mismatch ? syn_bits : '0;
        wr_bits   = rd_bits ^ flip_bits;
        wr_chk    = ^wr_bits;
    end

endmodule

// File: rtl/tdp_lane_tally.sv
// Per-lane verdict logic. It counts row parity mismatches seen during the
// scrub (saturating at two) and classifies the lane from that count and the
// number of syndrome bits set in the lane.
// Assumes clr is pulsed before the scrub and en is high only during it.
module tdp_lane_tally #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              mismatch,
    input  logic [LANE_W-1:0] syn_bits,
    output logic              fixed,
    output logic              bad
);

    logic [1:0] mis_q;
    logic       syn_one;
    logic       syn_many;

    // Saturating count of mismatching rows in this lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_q <= 2'd0;
        end else if (clr) begin
            mis_q <= 2'd0;
        end else if (en && mismatch && (mis_q != 2'd2)) begin
            mis_q <= mis_q + 2'd1;
        end
    end

    // Population of the lane's syndrome, reduced to one / more than one.
    always_comb begin
        int n;
        n = 0;
        for (int b = 0; b < LANE_W; b++) begin
            n = n + int'(syn_bits[b]);
        end
        syn_one  = (n == 1);
        syn_many = (n > 1);
    end

    // Lane verdict: uncorrectable wins over corrected.
    always_comb begin
        bad   = (mis_q == 2'd2) || syn_many;
        fixed = !bad && ((mis_q == 2'd1) || syn_one);
    end

endmodule

// File: rtl/tdp_seq_ctrl.sv
// Phase controller of the correction sequencer. It walks the syndrome pass
// from the row after the faulty one around the whole array, then the scrub
// pass from row 0 upward, and ends with a single finish cycle.
// Assumes trig_row < ROWS; triggers outside ST_IDLE are ignored.
module tdp_seq_ctrl
    import tdp_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [AW-1:0] trig_row,
    output seq_st_t       st,
    output logic [AW-1:0] row
);

    localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

    seq_st_t       st_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] cnt_q;

    // Row index that follows r, wrapping at the array end.
    function automatic logic [AW-1:0] next_row(input logic [AW-1:0] r);
        return (r == LAST_ROW) ? '0 : r + AW'(1);
    endfunction

    // Phase, row pointer and step count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (trig) begin
                        st_q  <= ST_SAVE;
                        ptr_q <= next_row(trig_row);
                        cnt_q <= '0;
                    end
                end
                ST_SAVE: begin
                    ptr_q <= next_row(ptr_q);
                    cnt_q <= cnt_q + AW'(1);
                    st_q  <= (ROWS == 1) ? ST_SYND : ST_ACCUM;
                end
                ST_ACCUM: begin
                    ptr_q <= next_row(ptr_q);
                    cnt_q <= cnt_q + AW'(1);
                    if (cnt_q == LAST_ROW) begin
                        st_q <= ST_SYND;
                    end
                end
                ST_SYND: begin
                    ptr_q <= '0;
                    cnt_q <= '0;
                    st_q  <= ST_SCRUB;
                end
                ST_SCRUB: begin
                    ptr_q <= next_row(ptr_q);
                    cnt_q <= cnt_q + AW'(1);
                    if (cnt_q == LAST_ROW) begin
                        st_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    st_q <= ST_IDLE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Present phase and row to the datapath.
    always_comb begin
        st  = st_q;
        row = ptr_q;
    end

endmodule

// File: rtl/tdp_scrub_seq.sv
// Two-dimensional parity correction sequencer, top level. It forms a column
// syndrome by reusing the external column check register as an accumulator,
// scrubs every row with per-lane repair and row check rewrite, rebuilds the
// column check register, and reports a per-lane verdict with a done pulse.
// Assumes same-cycle maintenance reads and that the column check register
// shows a written value from the next cycle on.
module tdp_scrub_seq
    import tdp_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int DW     = LANES * LANE_W,
    parameter int AW     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [AW-1:0]     trig_row_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [AW-1:0]     mnt_addr_o,
    input  logic [DW-1:0]     mnt_rdata_i,
    input  logic [LANES-1:0]  mnt_rchk_i,
    output logic              mnt_we_o,
    output logic [DW-1:0]     mnt_wdata_o,
    output logic [LANES-1:0]  mnt_wchk_o,
    input  logic [DW-1:0]     cc_q_i,
    output logic              cc_we_o,
    output logic [DW-1:0]     cc_d_o,
    output logic [LANES-1:0]  lane_fixed_o,
    output logic [LANES-1:0]  lane_bad_o
);

    seq_st_t          st;
    logic [AW-1:0]    row;
    logic [DW-1:0]    tmp_q;
    logic [DW-1:0]    syn_q;
    logic [DW-1:0]    flips_q;
    logic [DW-1:0]    flip_all;
    logic [DW-1:0]    fix_data;
    logic [LANES-1:0] fix_chk;
    logic [LANES-1:0] lane_mis;
    logic [LANES-1:0] lane_fixed;
    logic [LANES-1:0] lane_bad;

    tdp_seq_ctrl #(
        .ROWS (ROWS),
        .AW   (AW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_i),
        .trig_row (trig_row_i),
        .st       (st),
        .row      (row)
    );

    // One repair lane and one verdict tally per row check bit.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tdp_lane_fix #(
            .LANE_W (LANE_W)
        ) u_fix (
            .rd_bits   (mnt_rdata_i[l*LANE_W +: LANE_W]),
            .rd_chk    (mnt_rchk_i[l]),
            .syn_bits  (syn_q[l*LANE_W +: LANE_W]),
            .mismatch  (lane_mis[l]),
            .flip_bits (flip_all[l*LANE_W +: LANE_W]),
            .wr_bits   (fix_data[l*LANE_W +: LANE_W]),
            .wr_chk    (fix_chk[l])
        );

        tdp_lane_tally #(
            .LANE_W (LANE_W)
        ) u_tally (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (st == ST_SYND),
            .en       (st == ST_SCRUB),
            .mismatch (lane_mis[l]),
            .syn_bits (syn_q[l*LANE_W +: LANE_W]),
            .fixed    (lane_fixed[l]),
            .bad      (lane_bad[l])
        );
    end

    // Saved check bits, syndrome and accumulated scrub flips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q   <= '0;
            syn_q   <= '0;
            flips_q <= '0;
        end else begin
            case (st)
                ST_SAVE: begin
                    tmp_q   <= cc_q_i;
                    flips_q <= '0;
                end
                ST_SYND: begin
                    syn_q <= cc_q_i ^ tmp_q;
                end
                ST_SCRUB: begin
                    flips_q <= flips_q ^ flip_all;
                end
                default: begin
                end
            endcase
        end
    end

    // Column check register: load, accumulate, then rebuild at the end.
    always_comb begin
        cc_we_o = 1'b0;
        cc_d_o  = '0;
        case (st)
            ST_SAVE: begin
                cc_we_o = 1'b1;
                cc_d_o  = mnt_rdata_i;
            end
            ST_ACCUM: begin
                cc_we_o = 1'b1;
                cc_d_o  = cc_q_i ^ mnt_rdata_i;
            end
            ST_FIN: begin
                cc_we_o = 1'b1;
                cc_d_o  = cc_q_i ^ flips_q;
            end
            default: begin
            end
        endcase
    end

    // Maintenance port and status outputs.
    always_comb begin
        mnt_addr_o   = row;
        mnt_we_o     = (st == ST_SCRUB);
        mnt_wdata_o  = fix_data;
        mnt_wchk_o   = fix_chk;
        busy_o       = (st != ST_IDLE);
        done_o       = (st == ST_FIN);
        lane_fixed_o = done_o ? lane_fixed : '0;
        lane_bad_o   = done_o ? lane_bad : '0;
    end

endmodule

// File: rtl/tdp_scrub_seq_chk.sv
// Property checker for the correction sequencer, bound to its top module.
// Assumes the environment described in the brief (same-cycle reads).
module tdp_scrub_seq_chk #(
    parameter int ROWS   = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int DW     = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             mnt_we_o,
    input logic [DW-1:0]    mnt_wdata_o,
    input logic [LANES-1:0] mnt_wchk_o,
    input logic             cc_we_o,
    input logic [LANES-1:0] lane_fixed_o,
    input logic [LANES-1:0] lane_bad_o
);

    localparam int RUN_LEN = 2 * ROWS + 2;

    int unsigned busy_cnt;

    // Count of busy cycles preceding the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    // Lane parity of a written word.
    function automatic logic [LANES-1:0] lane_par(input logic [DW-1:0] d);
        logic [LANES-1:0] p;
        p = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < LANE_W; b++) begin
                p[l] = p[l] ^ d[l*LANE_W + b];
            end
        end
        return p;
    endfunction

    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == RUN_LEN - 1));

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i));

    assert_no_mem_write_in_cc_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we_o |-> !mnt_we_o);

    assert_write_only_in_scrub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_we_o |-> (busy_o && !done_o));

    assert_row_check_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_we_o |-> (mnt_wchk_o == lane_par(mnt_wdata_o)));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_fixed_o & lane_bad_o) == '0);

    assert_flags_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ((lane_fixed_o == '0) && (lane_bad_o == '0)));

    assert_retrigger_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o && !done_o) |=> busy_o);

endmodule

bind tdp_scrub_seq tdp_scrub_seq_chk #(
    .ROWS   (ROWS),
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .DW     (DW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mnt_we_o     (mnt_we_o),
    .mnt_wdata_o  (mnt_wdata_o),
    .mnt_wchk_o   (mnt_wchk_o),
    .cc_we_o      (cc_we_o),
    .lane_fixed_o (lane_fixed_o),
    .lane_bad_o   (lane_bad_o)
);

// File: tb/tdp_scrub_seq_bench.sv
// Bench for the correction sequencer: a behavioural memory with column check
// register, fault injection while idle, and a cycle-by-cycle reference of
// the expected port activity and final array contents.
module tdp_scrub_seq_bench;

    localparam int ROWS   = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DW     = LANES * LANE_W;
    localparam int AW     = 3;
    localparam int LAST_K = 2 * ROWS + 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             trig_i;
    logic [AW-1:0]    trig_row_i;
    logic             busy_o, done_o, mnt_we_o, cc_we_o;
    logic [AW-1:0]    mnt_addr_o;
    logic [DW-1:0]    mnt_rdata_i, mnt_wdata_o, cc_q_i, cc_d_o;
    logic [LANES-1:0] mnt_rchk_i, mnt_wchk_o, lane_fixed_o, lane_bad_o;

    logic [DW-1:0]    mem_d [ROWS];
    logic [LANES-1:0] mem_c [ROWS];
    logic [DW-1:0]    cc_reg;
    logic [DW-1:0]    gold_d [ROWS];
    logic [LANES-1:0] gold_c [ROWS];
    logic [DW-1:0]    gold_cc;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    tdp_scrub_seq #(
        .ROWS (ROWS), .LANES (LANES), .LANE_W (LANE_W)
    ) u_tdp_scrub_seq (
        .clk (clk), .rst_n (rst_n), .trig_i (trig_i), .trig_row_i (trig_row_i),
        .busy_o (busy_o), .done_o (done_o), .mnt_addr_o (mnt_addr_o),
        .mnt_rdata_i (mnt_rdata_i), .mnt_rchk_i (mnt_rchk_i),
        .mnt_we_o (mnt_we_o), .mnt_wdata_o (mnt_wdata_o), .mnt_wchk_o (mnt_wchk_o),
        .cc_q_i (cc_q_i), .cc_we_o (cc_we_o), .cc_d_o (cc_d_o),
        .lane_fixed_o (lane_fixed_o), .lane_bad_o (lane_bad_o)
    );

    // Behavioural memory: same-cycle read, write at the clock edge.
    assign mnt_rdata_i = mem_d[mnt_addr_o];
    assign mnt_rchk_i  = mem_c[mnt_addr_o];
    assign cc_q_i      = cc_reg;

    always @(posedge clk) begin
        if (mnt_we_o) begin
            mem_d[mnt_addr_o] <= mnt_wdata_o;
            mem_c[mnt_addr_o] <= mnt_wchk_o;
        end
        if (cc_we_o) cc_reg <= cc_d_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [LANES-1:0] par_of(input logic [DW-1:0] d);
        logic [LANES-1:0] p = '0;
        for (int i = 0; i < DW; i++) p[i / LANE_W] = p[i / LANE_W] ^ d[i];
        return p;
    endfunction

    task automatic restore();
        for (int r = 0; r < ROWS; r++) begin
            mem_d[r] <= gold_d[r];
            mem_c[r] <= gold_c[r];
        end
        cc_reg <= gold_cc;
        #1;
    endtask

    // Runs one repair: builds expectations, triggers, checks every cycle.
    task automatic run_case(input string tag, input int trow, input int rk, input int rrow,
                            input logic [LANES-1:0] fx, input logic [LANES-1:0] bx);
        logic [DW-1:0]    act_par, syn, e_cc;
        logic [DW-1:0]    e_d [ROWS];
        logic [LANES-1:0] e_c [ROWS];
        int               exp_addr;
        bit               exp_we, exp_ccwe, acc;
        act_par = '0;
        for (int r = 0; r < ROWS; r++) act_par ^= mem_d[r];
        syn  = act_par ^ cc_reg;
        e_cc = '0;
        for (int r = 0; r < ROWS; r++) begin
            e_d[r] = mem_d[r];
            for (int l = 0; l < LANES; l++) begin
                if (par_of(mem_d[r])[l] != mem_c[r][l]) begin
                    for (int b = 0; b < LANE_W; b++)
                        e_d[r][l*LANE_W + b] ^= syn[l*LANE_W + b];
                end
            end
            e_c[r] = par_of(e_d[r]);
            e_cc ^= e_d[r];
        end

        @(negedge clk);
        trig_i = 1'b1;
        trig_row_i = AW'(trow);
        for (int k = 0; k <= LAST_K; k++) begin
            @(negedge clk);
            trig_i = 1'b0;
            exp_we   = (k > ROWS) && (k <= 2 * ROWS);
            exp_ccwe = (k < ROWS) || (k == LAST_K);
            acc      = (k < ROWS) || exp_we;
            exp_addr = (k < ROWS) ? (trow + 1 + k) % ROWS : k - ROWS - 1;
            check(busy_o == 1'b1, "R2", {tag, " busy"}, busy_o, 1);
            check(done_o == (k == LAST_K), "R2", {tag, " done"}, done_o, (k == LAST_K));
            check(mnt_we_o == exp_we, "R4", {tag, " mem write enable"}, mnt_we_o, exp_we);
            check(cc_we_o == exp_ccwe, "R3", {tag, " column write enable"}, cc_we_o, exp_ccwe);
            if (acc)
                check(int'(mnt_addr_o) == exp_addr, (k < ROWS) ? "R3" : "R4",
                      {tag, " row order"}, mnt_addr_o, exp_addr);
            if (k == ROWS)
                check(cc_reg == act_par, "R3", {tag, " accumulated column parity"}, cc_reg, act_par);
            if (k == LAST_K) begin
                check(lane_fixed_o == fx, "R7", {tag, " corrected flags"}, lane_fixed_o, fx);
                check(lane_bad_o == bx, "R7", {tag, " uncorrectable flags"}, lane_bad_o, bx);
            end else begin
                check(lane_fixed_o == '0 && lane_bad_o == '0, "R7", {tag, " flags outside done"},
                      {lane_fixed_o, lane_bad_o}, 0);
            end
            if (k == rk) begin
                trig_i = 1'b1;
                trig_row_i = AW'(rrow);
            end
        end
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R2", {tag, " back to idle"}, busy_o, 0);
        for (int r = 0; r < ROWS; r++) begin
            check(mem_d[r] == e_d[r], "R4", {tag, " scrubbed data"}, mem_d[r], e_d[r]);
            check(mem_c[r] == e_c[r], "R5", {tag, " row check bits"}, mem_c[r], e_c[r]);
            if (bx == '0) begin
                check(mem_d[r] == gold_d[r], "R4", {tag, " data restored"}, mem_d[r], gold_d[r]);
                check(mem_c[r] == gold_c[r], "R10", {tag, " check bits restored"}, mem_c[r], gold_c[r]);
            end
        end
        check(cc_reg == e_cc, "R6", {tag, " rebuilt column checks"}, cc_reg, e_cc);
    endtask

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        trig_i = 1'b0;
        trig_row_i = '0;
        gold_cc = '0;
        for (int r = 0; r < ROWS; r++) begin
            gold_d[r] = $urandom;
            gold_c[r] = par_of(gold_d[r]);
            gold_cc ^= gold_d[r];
        end
        restore();
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !mnt_we_o && !cc_we_o, "R1", "outputs in reset",
              {busy_o, done_o, mnt_we_o, cc_we_o}, 0);
        check(lane_fixed_o == '0 && lane_bad_o == '0, "R1", "flags in reset",
              {lane_fixed_o, lane_bad_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !done_o && !mnt_we_o && !cc_we_o, "R1", "idle after reset",
              {busy_o, done_o, mnt_we_o, cc_we_o}, 0);

        // Single data upset, bit 20 of row 2 (lane 2).
        restore(); mem_d[2][20] <= ~mem_d[2][20]; #1;
        run_case("single data R4", 2, -1, 0, 4'b0100, 4'b0000);

        // Flipped row check bit of lane 1, row 5.
        restore(); mem_c[5][1] <= ~mem_c[5][1]; #1;
        run_case("row check upset R10", 5, -1, 0, 4'b0010, 4'b0000);

        // Two upsets in row 3, lane 0: row parity hides them.
        restore(); mem_d[3][1] <= ~mem_d[3][1]; mem_d[3][5] <= ~mem_d[3][5]; #1;
        run_case("same row double R8", 3, -1, 0, 4'b0000, 4'b0001);

        // Two upsets in column 30, rows 1 and 6: two row mismatches.
        restore(); mem_d[1][30] <= ~mem_d[1][30]; mem_d[6][30] <= ~mem_d[6][30]; #1;
        run_case("two rows one lane R7", 1, -1, 0, 4'b0000, 4'b1000);

        // Independent upsets in lanes 0 and 3, trigger on the last row (wrap).
        restore(); mem_d[0][3] <= ~mem_d[0][3]; mem_d[7][31] <= ~mem_d[7][31]; #1;
        run_case("two lanes wrap R3", 7, -1, 0, 4'b1001, 4'b0000);

        // Clean array: nothing to repair.
        restore();
        run_case("clean R7", 4, -1, 0, 4'b0000, 4'b0000);

        // Flipped column check bit 9 (lane 1).
        restore(); cc_reg[9] <= ~cc_reg[9]; #1;
        run_case("column check upset R10", 0, -1, 0, 4'b0010, 4'b0000);

        // Retrigger during the repair must be ignored.
        restore(); mem_d[4][12] <= ~mem_d[4][12]; #1;
        run_case("retrigger R9", 4, 3, 0, 4'b0010, 4'b0000);
        restore(); mem_d[6][0] <= ~mem_d[6][0]; #1;
        run_case("retrigger in scrub R9", 6, ROWS + 3, 1, 4'b0001, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule